// File: doc/BRIEF.md
# Four-Slot Macro-Operation Issue Checker

This block stands between the instruction fetch path and four asymmetric execution units. On every clock it takes one macro-operation of four fixed-width operation words. Each word goes to one unit. The block tests each word against the kind of unit that will run it. It then registers the whole group and forwards every word to its unit. A per-slot valid strobe is raised only for real, legal work.

Two unit kinds exist. The low slots drive the memory/control units, which run loads, stores and calls. The high slots drive the arithmetic units. A slot with nothing to do must carry an explicit no-operation code.

If any word is illegal for its slot, the group is squashed as a whole and a fault is raised. The fault names the lowest offending slot. Two plain stores to the same absolute address inside one group are resolved in favour of the higher memory slot, and a conflict flag is raised. A stall input freezes the forwarded words and silences every strobe.

Top module: `issue_check`

## Requirements
- R1: Slot i occupies bits [32*i+31:32*i] of `mop_i`, and its opcode class is bits [31:28] of that word. Opcode 0 is a NOP. A NOP is legal in every slot and never raises that slot's strobe.
- R2: Slots 0 and 1 (memory units) accept opcodes 1 (load constant), 2 (load), 3 (store), 4 (indexed load), 5 (indexed store) and 6 (call). Every arithmetic opcode is illegal there.
- R3: Slots 2 and 3 (arithmetic units) accept opcodes 8 to 13 (add, sub, mul, div, rem, sign change). Every memory/control opcode is illegal there.
- R4: Opcodes 7, 14 and 15 are illegal in every slot. If any slot is illegal, `fault_o` is 1 and all of `vld_o` is 0 for that group.
- R5: When several slots are illegal, `fault_idx_o` reports the lowest illegal slot index.
- R6: If both memory slots hold opcode 3 with equal address bits [15:0], `conflict_o` is 1. In that case slot 0's strobe is dropped and slot 1's store still issues.
- R7: One cycle after a non-stalled edge, `op_o` holds the captured macro-operation in the same layout. `vld_o[i]` is 1 exactly for the legal, non-NOP slots that were not dropped.
- R8: While `stall_i` is 1 at an edge, `op_o` keeps its value, and `vld_o`, `fault_o` and `conflict_o` go to 0 after that edge.
- R9: Reset is synchronous and active low. It clears `op_o`, `vld_o`, `fault_o`, `fault_idx_o` and `conflict_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Hold the forwarded group and suppress strobes |
| mop_i | input | 128 | Incoming macro-operation, four 32-bit slot words |
| op_o | output | 128 | Registered slot words forwarded to the units |
| vld_o | output | 4 | Per-slot issue strobe |
| fault_o | output | 1 | Group was squashed because a slot was illegal |
| fault_idx_o | output | 2 | Lowest illegal slot index |
| conflict_o | output | 1 | Two stores to one address were seen in this group |

## Verification
The bound assertions check several relations on every cycle. A fault never coexists with a strobe. A NOP slot never strobes. The reported fault index points at a slot whose forwarded opcode is illegal, and all slots below it are legal. A conflict leaves only the higher store issuing. A stall holds the words and silences the strobes.

Only the bench scenarios can show the exact mapping from each opcode to each unit kind. They also show that unlisted codes are rejected, that a load and a store to the same address do not count as a conflict, and that stalled groups leave no trace after release.

// File: rtl/issue_check_pkg.sv
// Package: shared opcode classes and slot-legality helpers for the issue checker.
// Assumes a 4-bit opcode class in the top nibble of every slot word.
package issue_check_pkg;

    localparam int OPC_W  = 4;
    localparam int ADDR_W = 16;

    localparam logic [OPC_W-1:0] OPC_NOP   = 4'd0;
    localparam logic [OPC_W-1:0] OPC_LDC   = 4'd1;
    localparam logic [OPC_W-1:0] OPC_LD    = 4'd2;
    localparam logic [OPC_W-1:0] OPC_ST    = 4'd3;
    localparam logic [OPC_W-1:0] OPC_LDA   = 4'd4;
    localparam logic [OPC_W-1:0] OPC_STA   = 4'd5;
    localparam logic [OPC_W-1:0] OPC_CALL  = 4'd6;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'd8;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'd9;
    localparam logic [OPC_W-1:0] OPC_MUL   = 4'd10;
    localparam logic [OPC_W-1:0] OPC_DIV   = 4'd11;
    localparam logic [OPC_W-1:0] OPC_REM   = 4'd12;
    localparam logic [OPC_W-1:0] OPC_NEG   = 4'd13;

    typedef enum logic {UNIT_MEM, UNIT_ALU} unit_e;

    // True for codes that a memory/control unit runs.
    function automatic logic is_mem_code(logic [OPC_W-1:0] opc);
        return (opc >= OPC_LDC) && (opc <= OPC_CALL);
    endfunction

    // True for codes that an arithmetic unit runs.
    function automatic logic is_alu_code(logic [OPC_W-1:0] opc);
        return (opc >= OPC_ADD) && (opc <= OPC_NEG);
    endfunction

endpackage

// File: rtl/slot_legal.sv
// Module: per-slot legality test for one execution-unit kind.
// Assumes the opcode class has already been sliced out of the slot word.
// The unit kind parameter picks which opcode family is accepted.
module slot_legal
    import issue_check_pkg::*;
#(
    parameter unit_e UNIT_KIND = UNIT_MEM
) (
    input  logic [OPC_W-1:0] opc_i,
    output logic             legal_o,
    output logic             busy_o,
    output logic             store_o
);

    logic nop;
    assign nop    = (opc_i == OPC_NOP);
    assign busy_o = !nop;

    generate
        if (UNIT_KIND == UNIT_MEM) begin : g_mem
            // Memory/control slot: accept loads, stores, call.
            always_comb begin
                legal_o = nop || is_mem_code(opc_i);
                store_o = (opc_i == OPC_ST);
            end
        end else begin : g_alu
            // Arithmetic slot: accept arithmetic family only; never a store.
            always_comb begin
                legal_o = nop || is_alu_code(opc_i);
                store_o = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/store_arbiter.sv
// Module: same-address store resolution among the memory slots.
// Assumes only absolute-address stores are compared; indexed stores cannot
// be resolved before register read and pass untouched.
// A store loses when any higher memory slot stores to the same address.
module store_arbiter
    import issue_check_pkg::*;
#(
    parameter int MEM_SLOTS = 2
) (
    input  logic [MEM_SLOTS-1:0]        store_i,
    input  logic [MEM_SLOTS*ADDR_W-1:0] addr_i,
    output logic [MEM_SLOTS-1:0]        drop_o,
    output logic                        conflict_o
);

    // Pairwise compare: lower slot j is dropped by a matching higher slot i.
    always_comb begin
        drop_o = '0;
        for (int j = 0; j < MEM_SLOTS; j++) begin
            for (int i = j + 1; i < MEM_SLOTS; i++) begin
                if (store_i[j] && store_i[i] &&
                    addr_i[j*ADDR_W +: ADDR_W] == addr_i[i*ADDR_W +: ADDR_W])
                    drop_o[j] = 1'b1;
            end
        end
    end

    // Any dropped store means a conflict was present.
    assign conflict_o = |drop_o;

endmodule

// File: rtl/fault_pick.sv
// Module: priority encoder choosing the lowest illegal slot.
// Assumes NUM_SLOTS >= 2 so the index width is at least one bit.
module fault_pick #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] bad_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     idx_o
);

    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx_o = '0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (bad_i[k]) idx_o = IDX_W'(k);
        end
    end

    assign any_o = |bad_i;

endmodule

// File: rtl/issue_check.sv
// Module: four-slot macro-operation issue checker (top).
// Validates each slot against its unit kind, resolves same-address stores,
// and registers the group with per-slot strobes. Slots below MEM_SLOTS feed
// memory/control units; the rest feed arithmetic units.
module issue_check
    import issue_check_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int MEM_SLOTS = 2,
    parameter int SLOT_W    = 32,
    localparam int MOP_W    = NUM_SLOTS * SLOT_W,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_i,
    input  logic [MOP_W-1:0] mop_i,
    output logic [MOP_W-1:0] op_o,
    output logic [NUM_SLOTS-1:0] vld_o,
    output logic             fault_o,
    output logic [IDX_W-1:0] fault_idx_o,
    output logic             conflict_o
);

    logic [NUM_SLOTS-1:0]        legal;
    logic [NUM_SLOTS-1:0]        busy;
    logic [NUM_SLOTS-1:0]        store;
    logic [MEM_SLOTS-1:0]        mem_drop;
    logic [MEM_SLOTS*ADDR_W-1:0] mem_addr;
    logic [NUM_SLOTS-1:0]        drop;
    logic                        any_bad;
    logic [IDX_W-1:0]            bad_idx;
    logic                        conflict;
    logic [NUM_SLOTS-1:0]        issue_mask;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            if (s < MEM_SLOTS) begin : g_mem_slot
                slot_legal #(.UNIT_KIND(UNIT_MEM)) u_legal (
                    .opc_i  (mop_i[s*SLOT_W + SLOT_W - OPC_W +: OPC_W]),
                    .legal_o(legal[s]),
                    .busy_o (busy[s]),
                    .store_o(store[s])
                );
                // Absolute store address lives in the low field of the word.
                assign mem_addr[s*ADDR_W +: ADDR_W] = mop_i[s*SLOT_W +: ADDR_W];
                assign drop[s] = mem_drop[s];
            end else begin : g_alu_slot
                slot_legal #(.UNIT_KIND(UNIT_ALU)) u_legal (
                    .opc_i  (mop_i[s*SLOT_W + SLOT_W - OPC_W +: OPC_W]),
                    .legal_o(legal[s]),
                    .busy_o (busy[s]),
                    .store_o(store[s])
                );
                assign drop[s] = 1'b0;
            end
        end
    endgenerate

    store_arbiter #(.MEM_SLOTS(MEM_SLOTS)) u_arb (
        .store_i   (store[MEM_SLOTS-1:0]),
        .addr_i    (mem_addr),
        .drop_o    (mem_drop),
        .conflict_o(conflict)
    );

    fault_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .bad_i(~legal),
        .any_o(any_bad),
        .idx_o(bad_idx)
    );

    // Strobe mask: real work, not dropped, and the group is clean.
    assign issue_mask = any_bad ? '0 : (busy & ~drop);

    // Output register: capture on free cycles, hold words and go quiet on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_o        <= '0;
            vld_o       <= '0;
            fault_o     <= 1'b0;
            fault_idx_o <= '0;
            conflict_o  <= 1'b0;
        end else if (stall_i) begin
            vld_o      <= '0;
            fault_o    <= 1'b0;
            conflict_o <= 1'b0;
        end else begin
            op_o        <= mop_i;
            vld_o       <= issue_mask;
            fault_o     <= any_bad;
            fault_idx_o <= bad_idx;
            conflict_o  <= conflict;
        end
    end

endmodule

// File: rtl/issue_check_sva.sv
// Module: assertion checker bound to issue_check; observes its ports only.
module issue_check_sva
    import issue_check_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int MEM_SLOTS = 2,
    parameter int SLOT_W    = 32,
    localparam int MOP_W    = NUM_SLOTS * SLOT_W,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stall_i,
    input logic [MOP_W-1:0]     mop_i,
    input logic [MOP_W-1:0]     op_o,
    input logic [NUM_SLOTS-1:0] vld_o,
    input logic                 fault_o,
    input logic [IDX_W-1:0]     fault_idx_o,
    input logic                 conflict_o
);

    // Opcode of forwarded slot k.
    function automatic logic [OPC_W-1:0] opc_at(logic [MOP_W-1:0] v, int k);
        return v[k*SLOT_W + SLOT_W - OPC_W +: OPC_W];
    endfunction

    // Independent statement of legality per slot position.
    function automatic logic ok_at(logic [MOP_W-1:0] v, int k);
        logic [OPC_W-1:0] o;
        o = opc_at(v, k);
        if (o == OPC_NOP) return 1'b1;
        return (k < MEM_SLOTS) ? is_mem_code(o) : is_alu_code(o);
    endfunction

    AST_FAULT_SQUASHES: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (vld_o == '0)); // R4

    AST_FAULT_SLOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !ok_at(op_o, int'(fault_idx_o))); // R5

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> (vld_o == '0) && !fault_o && $stable(op_o)); // R8

    AST_CONFLICT_HIGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_o && !fault_o) |-> (vld_o[1] && !vld_o[0])); // R6

    generate
        for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
            AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (opc_at(op_o, k) == OPC_NOP) |-> !vld_o[k]); // R1
            AST_LOWER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
                (fault_o && int'(fault_idx_o) > k) |-> ok_at(op_o, k)); // R5
            AST_STROBE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
                vld_o[k] |-> ok_at(op_o, k)); // R7
        end
    endgenerate

endmodule

bind issue_check issue_check_sva #(
    .NUM_SLOTS(NUM_SLOTS),
    .MEM_SLOTS(MEM_SLOTS),
    .SLOT_W   (SLOT_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_i    (stall_i),
    .mop_i      (mop_i),
    .op_o       (op_o),
    .vld_o      (vld_o),
    .fault_o    (fault_o),
    .fault_idx_o(fault_idx_o),
    .conflict_o (conflict_o)
);

// File: tb/sim_issue_check.sv
`timescale 1ns/1ps
module sim_issue_check;

    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         stall_i;
    logic [127:0] mop_i;
    logic [127:0] op_o;
    logic [3:0]   vld_o;
    logic         fault_o;
    logic [1:0]   fault_idx_o;
    logic         conflict_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    issue_check u0 (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .mop_i(mop_i),
        .op_o(op_o), .vld_o(vld_o), .fault_o(fault_o),
        .fault_idx_o(fault_idx_o), .conflict_o(conflict_o)
    );

    // Build one slot word: opcode class on top, address in the low field.
    function automatic logic [31:0] w(logic [3:0] opc, logic [15:0] addr);
        return {opc, 12'h0, addr};
    endfunction

    // Vector layout: {mop[127:0], vld[3:0], fault, idx[1:0], conflict}.
    localparam logic [135:0] VEC [NV] = '{
        {w(0,0),    w(0,0),    w(0,0),  w(0,0),  4'b0000, 1'b0, 2'd0, 1'b0},
        {w(9,0),    w(8,0),    w(2,7),  w(1,3),  4'b1111, 1'b0, 2'd0, 1'b0},
        {w(10,0),   w(0,0),    w(3,5),  w(3,5),  4'b1010, 1'b0, 2'd0, 1'b1},
        {w(12,0),   w(11,0),   w(3,6),  w(3,5),  4'b1111, 1'b0, 2'd0, 1'b0},
        {w(0,0),    w(0,0),    w(0,0),  w(8,0),  4'b0000, 1'b1, 2'd0, 1'b0},
        {w(8,0),    w(2,1),    w(5,0),  w(6,0),  4'b0000, 1'b1, 2'd2, 1'b0},
        {w(7,0),    w(13,0),   w(0,0),  w(0,0),  4'b0000, 1'b1, 2'd3, 1'b0},
        {w(2,0),    w(0,0),    w(15,0), w(8,0),  4'b0000, 1'b1, 2'd0, 1'b0},
        {w(0,0),    w(0,0),    w(6,0),  w(4,0),  4'b0011, 1'b0, 2'd0, 1'b0},
        {w(0,0),    w(2,0),    w(3,5),  w(3,5),  4'b0000, 1'b1, 2'd2, 1'b1},
        {w(0,0),    w(0,0),    w(3,5),  w(2,5),  4'b0011, 1'b0, 2'd0, 1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            0:       return "R1";
            1:       return "R7";
            2, 3:    return "R6";
            4:       return "R2";
            5:       return "R3";
            6:       return "R4";
            7:       return "R5";
            8:       return "R2";
            9:       return "R6";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Present one group at a falling edge; outputs are valid at the next falling edge.
    task automatic step(logic [127:0] mop, logic stall);
        mop_i   = mop;
        stall_i = stall;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        stall_i = 1'b0;
        mop_i   = {4{w(2,9)}};
        @(negedge clk);
        @(negedge clk);
        // R9: reset clears every output.
        check("R9", "op",   op_o, '0);
        check("R9", "vld",  128'(vld_o), '0);
        check("R9", "flag", 128'({fault_o, fault_idx_o, conflict_o}), '0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [135:0] v;
            v = VEC[i];
            step(v[135:8], 1'b0);
            check(tag_of(i), "op",    op_o, v[135:8]);
            check(tag_of(i), "vld",   128'(vld_o), 128'(v[7:4]));
            check(tag_of(i), "fault", 128'(fault_o), 128'(v[3]));
            if (v[3]) check("R5", "idx", 128'(fault_idx_o), 128'(v[2:1]));
            check(tag_of(i), "conflict", 128'(conflict_o), 128'(v[0]));
        end

        // R8: stall holds the forwarded group and silences strobes.
        step({w(9,0), w(8,0), w(2,7), w(1,3)}, 1'b0);
        step({w(0,0), w(0,0), w(3,5), w(3,5)}, 1'b1);
        check("R8", "op held", op_o, {w(9,0), w(8,0), w(2,7), w(1,3)});
        check("R8", "vld",     128'(vld_o), '0);
        check("R8", "conflict", 128'(conflict_o), '0);
        step({w(8,0), w(8,0), w(8,0), w(8,0)}, 1'b1);
        check("R8", "fault", 128'(fault_o), '0);
        // Release: new group takes effect.
        step({w(13,0), w(0,0), w(0,0), w(6,0)}, 1'b0);
        check("R7", "op after release", op_o, {w(13,0), w(0,0), w(0,0), w(6,0)});
        check("R7", "vld after release", 128'(vld_o), 128'(4'b1001));

        // R9: reset in the middle of traffic.
        rst_n = 1'b0;
        step({w(9,0), w(8,0), w(2,7), w(1,3)}, 1'b0);
        check("R9", "vld mid reset", 128'(vld_o), '0);
        check("R9", "op mid reset", op_o, '0);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule